// File: doc/BRIEF.md
# Command-Enabled Periodic Reset Watchdog

This block produces a periodic active-low reset for a host that has stopped responding. It does nothing until two conditions hold. A command decoder must have sent the enable command number, and the supply-valid flag must have stayed true without a break for a settling time. When both hold, the block raises its pending flag and counts down a fixed period. If the period ends without a clear in time, the block drives the reset line low for a fixed width. It then raises pending again and starts a new period.

The host keeps its reset from firing by driving the clear input high while at least a minimum margin of the period is left. A clear that arrives inside that final margin is ignored, and the reset still fires. A clear in time skips the reset and starts the next period at the expiry point. The disable command can arrive at any time and returns the block to its default state: reset line high, pending low. If the supply-valid flag drops, the block loses its qualification and must settle again. An enable command that arrives before qualification is held and takes effect once the settling time has passed.

All timing runs on a tick made by dividing the clock, one microsecond by default. With that tick, the settle time (150 ms), the period (4000 ms), the clear margin (100 µs) and the reset width (10 ms) are all exact tick counts.

Top module: `reset_watchdog`

## Requirements
- R1: After reset, `wdg_rst_n` is high and `pending` is low.
- R2: A cycle with `cmd_valid` high and `cmd_num` = 27 sets the enable. `cmd_num` = 26 clears it. Any other command number, or any value while `cmd_valid` is low, has no effect.
- R3: The block arms only after `supply_ok` has been high without a break for SETTLE_TICKS ticks. An enable given before then is held and arms the block once the settle completes.
- R4: When armed, `pending` is high during a countdown of PERIOD_TICKS ticks, measured from the rise of `pending`.
- R5: If the countdown expires with no valid clear, `wdg_rst_n` goes low for PULSE_TICKS ticks, and `pending` is low during that pulse.
- R6: When the reset pulse ends, `pending` rises again and a new full countdown starts, so while no clear is given a pulse falls due every period.
- R7: If `clear_in` is high in any clock cycle when at least MARGIN_TICKS ticks of the countdown remain, the next expiry produces no pulse. `pending` stays high and the countdown restarts from the expiry point.
- R8: A clear seen only when fewer than MARGIN_TICKS ticks remain is ignored, and the pulse is still issued at expiry.
- R9: A disable command returns the block to idle within two cycles from any state, ending any countdown or pulse in progress: `wdg_rst_n` high, `pending` low.
- R10: A drop of `supply_ok` returns the block to idle within two cycles. A full new settle is needed before it arms again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from which the tick is divided |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| cmd_valid | input | 1 | Strobe for a decoded command number |
| cmd_num | input | CMD_W | Decoded command number |
| supply_ok | input | 1 | Supply-valid flag, already synchronised |
| clear_in | input | 1 | Host clear request, active high |
| wdg_rst_n | output | 1 | Watchdog reset output, active low |
| pending | output | 1 | High while a countdown is running |

## Verification
The assertions assume that `supply_ok`, `clear_in` and the command strobe are synchronous to `clk` and change only between edges. They also assume that a command number is valid for one cycle at a time. The bench drives every input on the falling edge and sends each command as a single-cycle strobe, so it stays inside these assumptions. The bench tests the clear margin a few ticks on each side of the boundary rather than on it. This keeps the result clear of the one-tick uncertainty in the phase of the free-running divider.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_COUNT = 2'd1,
    WD_PULSE = 2'd2
  } wd_state_e;

  // A clear is honoured while at least `margin` ticks of the period remain.
  function automatic logic clear_in_time(int elapsed, int period, int margin);
    return (period - elapsed) >= margin;
  endfunction

  // Counter width that can hold the value n.
  function automatic int width_for(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/wdg_tick.sv
module wdg_tick #(
  parameter int TICK_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = wdg_pkg::width_for(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          div_q <= '0;
        else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
        else                                 div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(TICK_DIV - 1));

      p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdg_settle.sv
module wdg_settle #(
  parameter int SETTLE_TICKS = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  output logic qualified
);
  localparam int SW = wdg_pkg::width_for(SETTLE_TICKS);
  logic [SW-1:0] run_q;
  logic          qual_q;
  logic          settle_done;

  assign settle_done = tick && (run_q == SW'(SETTLE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (!supply_ok) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else if (!qual_q && tick) begin
      if (settle_done) qual_q <= 1'b1;
      else             run_q  <= run_q + 1'b1;
    end
  end

  assign qualified = qual_q;

  p_settle_needs_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(supply_ok));
  p_drop_unqualifies_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !qualified);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int PERIOD_TICKS = 4000000,
  parameter int MARGIN_TICKS = 100,
  parameter int PULSE_TICKS  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic clear_in,
  output logic pending,
  output logic wdg_rst_n
);
  import wdg_pkg::*;

  localparam int MAXT = (PERIOD_TICKS > PULSE_TICKS) ? PERIOD_TICKS : PULSE_TICKS;
  localparam int CW   = width_for(MAXT);

  wd_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          clr_seen_q;

  // Named internal events, used by the next-state logic and the assertions.
  logic expire_evt, pulse_done, clear_hit, skip_now;

  assign expire_evt = (state_q == WD_COUNT) && tick && (cnt_q == CW'(PERIOD_TICKS - 1));
  assign pulse_done = (state_q == WD_PULSE) && tick && (cnt_q == CW'(PULSE_TICKS - 1));
  assign clear_hit  = (state_q == WD_COUNT) && clear_in &&
                      clear_in_time(int'(cnt_q), PERIOD_TICKS, MARGIN_TICKS);
  assign skip_now   = clr_seen_q || clear_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WD_IDLE;
      cnt_q      <= '0;
      clr_seen_q <= 1'b0;
    end else if (!armed) begin
      state_q    <= WD_IDLE;
      cnt_q      <= '0;
      clr_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        WD_IDLE: begin
          state_q    <= WD_COUNT;
          cnt_q      <= '0;
          clr_seen_q <= 1'b0;
        end
        WD_COUNT: begin
          if (clear_hit) clr_seen_q <= 1'b1;
          if (expire_evt) begin
            cnt_q      <= '0;
            clr_seen_q <= 1'b0;
            if (!skip_now) state_q <= WD_PULSE;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        WD_PULSE: begin
          if (pulse_done) begin
            state_q <= WD_COUNT;
            cnt_q   <= '0;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= WD_IDLE;
      endcase
    end
  end

  assign pending   = (state_q == WD_COUNT);
  assign wdg_rst_n = (state_q != WD_PULSE);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (int'(cnt_q) < PERIOD_TICKS));
  p_pulse_after_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdg_rst_n) |-> $past(expire_evt && !skip_now));
  p_restart_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_done && armed) |=> (pending && cnt_q == '0));
  p_skip_keeps_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && skip_now && armed) |=> (pending && wdg_rst_n));
  p_late_clear_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !clr_seen_q && armed &&
     !clear_in_time(PERIOD_TICKS - 1, PERIOD_TICKS, MARGIN_TICKS)) |=> !wdg_rst_n);
  p_disarm_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!pending && wdg_rst_n));
endmodule

// File: rtl/reset_watchdog.sv
module reset_watchdog #(
  parameter int TICK_DIV     = 250,
  parameter int SETTLE_TICKS = 150000,
  parameter int PERIOD_TICKS = 4000000,
  parameter int MARGIN_TICKS = 100,
  parameter int PULSE_TICKS  = 10000,
  parameter int CMD_W        = 6,
  parameter int CMD_ENABLE   = 27,
  parameter int CMD_DISABLE  = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_num,
  input  logic             supply_ok,
  input  logic             clear_in,
  output logic             wdg_rst_n,
  output logic             pending
);
  logic tick, qualified, en_q, armed;
  logic cmd_on, cmd_off;

  assign cmd_on  = cmd_valid && (cmd_num == CMD_W'(CMD_ENABLE));
  assign cmd_off = cmd_valid && (cmd_num == CMD_W'(CMD_DISABLE));

  // The enable is held independently of qualification (R3).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (cmd_off) en_q <= 1'b0;
    else if (cmd_on)  en_q <= 1'b1;
  end

  assign armed = en_q && qualified;

  wdg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  wdg_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .supply_ok(supply_ok), .qualified(qualified)
  );

  wdg_countdown #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .MARGIN_TICKS(MARGIN_TICKS),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_cd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(armed),
    .clear_in(clear_in), .pending(pending), .wdg_rst_n(wdg_rst_n)
  );

  p_disable_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> !en_q);
  p_unqualified_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !qualified |=> !pending);
endmodule

// File: tb/reset_watchdog_tb.sv
`timescale 1ns/1ps
module reset_watchdog_tb;
  localparam int TD = 2, SET = 20, PER = 100, MAR = 10, PUL = 8;
  localparam int PER_CYC = PER * TD, PUL_CYC = PUL * TD, TOL = 4;

  // Vector table: ticks remaining at the clear (-1 = none), expect pulse?
  localparam int NV = 6;
  localparam int VEC_REM [NV] = '{-1, 60, 14, 6, 2, -1};
  localparam bit VEC_RST [NV] = '{1, 0, 0, 1, 1, 1};

  logic clk = 0, rst_n = 0, cmd_valid = 0, supply_ok = 0, clear_in = 0;
  logic [5:0] cmd_num = '0;
  logic wdg_rst_n, pending;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  reset_watchdog #(.TICK_DIV(TD), .SETTLE_TICKS(SET), .PERIOD_TICKS(PER),
                   .MARGIN_TICKS(MAR), .PULSE_TICKS(PUL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_num(cmd_num),
    .supply_ok(supply_ok), .clear_in(clear_in),
    .wdg_rst_n(wdg_rst_n), .pending(pending));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input int n);
    @(negedge clk); cmd_valid = 1; cmd_num = 6'(n);
    @(negedge clk); cmd_valid = 0; cmd_num = '0;
  endtask

  task automatic wait_pending(output int c);
    c = 0;
    while (!pending && c < 400) begin @(negedge clk); c++; end
  endtask

  task automatic wait_fall(input int lim, output int c);
    c = 0;
    while (wdg_rst_n && c < lim) begin @(negedge clk); c++; end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c, fall_at, rise_at;
    cyc(3);
    check(wdg_rst_n === 1'b1 && pending === 1'b0, "R1", {wdg_rst_n, pending}, 2);
    rst_n = 1;
    cyc(2);
    check(wdg_rst_n === 1'b1 && pending === 1'b0, "R1", {wdg_rst_n, pending}, 2);

    // R3: enable before qualification is held.
    send_cmd(27);
    cyc(60);
    check(pending == 0, "R3 unqualified", pending, 0);
    supply_ok = 1;
    cyc(SET * TD - 6);
    check(pending == 0, "R3 still settling", pending, 0);
    cyc(12);
    check(pending == 1, "R3 armed after settle", pending, 1);

    // Vector table walk: R4 R5 R7 R8.
    for (int v = 0; v < NV; v++) begin
      int clr_at;
      send_cmd(26); cyc(4);
      send_cmd(27);
      wait_pending(c);
      check(pending == 1, "R2 enable arms", pending, 1);
      clr_at = (VEC_REM[v] < 0) ? -1 : (PER - VEC_REM[v]) * TD - 1;
      fall_at = -1;
      for (int k = 0; k < PER_CYC + 60; k++) begin
        if (k == clr_at) clear_in = 1;
        else clear_in = 0;
        @(negedge clk);
        if (fall_at < 0 && !wdg_rst_n) fall_at = k + 1;
      end
      clear_in = 0;
      if (VEC_RST[v]) begin
        check(fall_at >= PER_CYC - TOL && fall_at <= PER_CYC + TOL,
              (VEC_REM[v] < 0) ? "R5 expiry time" : "R8 late clear ignored",
              fall_at, PER_CYC);
      end else begin
        check(fall_at < 0, "R7 clear skips pulse", fall_at, -1);
        check(pending == 1, "R7 pending kept", pending, 1);
      end
    end

    // R5/R6: pulse width, then pending rises and the next period runs.
    send_cmd(26); cyc(4); send_cmd(27);
    wait_pending(c);
    wait_fall(PER_CYC + 20, c);
    check(pending == 0, "R5 pending low in pulse", pending, 0);
    rise_at = 0;
    while (!wdg_rst_n && rise_at < 100) begin @(negedge clk); rise_at++; end
    check(rise_at >= PUL_CYC - TOL && rise_at <= PUL_CYC + TOL, "R5 pulse width", rise_at, PUL_CYC);
    check(pending == 1, "R6 pending after pulse", pending, 1);
    wait_fall(PER_CYC + 20, c);
    check(c >= PER_CYC - TOL && c <= PER_CYC + TOL, "R6 repeat period", c, PER_CYC);
    rise_at = 0;
    while (!wdg_rst_n && rise_at < 100) begin @(negedge clk); rise_at++; end

    // R2: other command numbers have no effect.
    cyc(10);
    send_cmd(28); send_cmd(25);
    cyc(2);
    check(pending == 1, "R2 other cmd ignored", pending, 1);
    send_cmd(26); cyc(2);
    send_cmd(25);
    @(negedge clk); cmd_num = 6'd27; cyc(2); cmd_num = '0;
    cyc(10);
    check(pending == 0, "R2 no arm without strobe", pending, 0);

    // R9: disable mid-count, then no pulse later.
    send_cmd(27); wait_pending(c);
    cyc(50);
    send_cmd(26);
    cyc(1);
    check(pending == 0 && wdg_rst_n == 1, "R9 disable in count", pending, 0);
    wait_fall(PER_CYC + 40, c);
    check(c == PER_CYC + 40, "R9 no pulse when off", c, PER_CYC + 40);

    // R9: disable during the pulse.
    send_cmd(27); wait_pending(c);
    wait_fall(PER_CYC + 20, c);
    cyc(3);
    send_cmd(26);
    cyc(1);
    check(wdg_rst_n == 1 && pending == 0, "R9 disable in pulse", wdg_rst_n, 1);

    // R10: supply drop, then full settle again.
    send_cmd(27); wait_pending(c);
    cyc(20);
    supply_ok = 0;
    cyc(2);
    check(pending == 0 && wdg_rst_n == 1, "R10 drop to idle", pending, 0);
    cyc(4);
    supply_ok = 1;
    cyc(SET * TD - 6);
    check(pending == 0, "R10 resettle needed", pending, 0);
    cyc(12);
    check(pending == 1, "R10 rearmed", pending, 1);

    finish_run();
  end
endmodule